// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

A bank of eight single-bit ownership tokens shared by a left and a right port. The tokens are not part of any data store. Each port claims a token by writing a zero to its slot and learns whether it succeeded by reading the slot back. A zero means that port now holds the token. A one means it does not hold it: either the other port holds it or the token is free.

When a port asks for a token that the other side holds, the request is remembered. When the holder releases the token, the waiting port receives it on the same clock edge and does not need to write again. Writing a one gives up a held token or withdraws a waiting request. If both ports claim a free token in the same cycle, the left port wins and the right port's request waits. Read-back is returned only after the port has dropped its select or its output enable at least once since its last write.

Top module: `sem_bank`

## Requirements
- R1: After reset every token is free and nothing is pending, so both ports read one from all eight slots.
- R2: Writing a zero (bit 0 of the write data) to a free slot gives that port the token. That port then reads zero and the other port reads one, and the two ports never both read zero from the same slot.
- R3: The slot is chosen by the three lowest address bits. All higher address bits are ignored for both writes and reads.
- R4: A zero written by a port while the other port holds the token leaves that port reading one and records a pending request. When the holder writes a one, the waiting port owns the token at that edge, with no further write.
- R5: A non-holder that writes a one withdraws its pending request. A later release by the holder then leaves the token free, and a fresh request is granted at once.
- R6: When both ports write a zero to the same free slot in one cycle, the left port gets the token and the right request stays pending. The right port takes over when the left port releases.
- R7: An access made while the port's memory enable is high does nothing. A write changes no token, and a read returns the not-valid output.
- R8: After a write, a port's reads stay not-valid until that port has had its select or its output enable low for at least one clock edge.
- R9: A valid read raises the read-valid output and repeats the token bit on every data line. Otherwise the read-valid output is low and all data lines are one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| l_sem_sel_i | input | 1 | Left semaphore select |
| l_mem_en_i | input | 1 | Left memory enable; must be low during a semaphore access |
| l_wr_i | input | 1 | Left write strobe (1 = write, 0 = read) |
| l_oe_i | input | 1 | Left output enable |
| l_addr_i | input | ADDR_W | Left address; low three bits pick the slot |
| l_wdata_i | input | DATA_W | Left write data; bit 0 is the token value |
| l_rdata_o | output | DATA_W | Left read data |
| l_rd_vld_o | output | 1 | Left read data valid |
| r_sem_sel_i | input | 1 | Right semaphore select |
| r_mem_en_i | input | 1 | Right memory enable; must be low during a semaphore access |
| r_wr_i | input | 1 | Right write strobe (1 = write, 0 = read) |
| r_oe_i | input | 1 | Right output enable |
| r_addr_i | input | ADDR_W | Right address; low three bits pick the slot |
| r_wdata_i | input | DATA_W | Right write data; bit 0 is the token value |
| r_rdata_o | output | DATA_W | Right read data |
| r_rd_vld_o | output | 1 | Right read data valid |

## Verification
The bench uses the defaults: eight slots, a 12-bit address and a 16-bit data bus. With the 12-bit address, the bench can set upper address bits and show that they do not change which slot is used. With the 16-bit bus, it can check that the token bit appears on every data line. It runs the ordered cases that matter most: a handover to a waiting port, a withdrawn request, a same-cycle claim by both ports, and a read held high straight after a write.

// File: rtl/sem_bank_pkg.sv
package sem_bank_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } own_e;
endpackage

// File: rtl/sem_port_dec.sv
module sem_port_dec #(
  parameter int NUM_SEM = 8,
  parameter int ADDR_W  = 12,
  localparam int IDX_W  = (NUM_SEM > 1) ? $clog2(NUM_SEM) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sel_i,
  input  logic               mem_en_i,
  input  logic               wr_i,
  input  logic               oe_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wbit_i,
  output logic [NUM_SEM-1:0] req_o,
  output logic [NUM_SEM-1:0] rel_o,
  output logic               rd_o,
  output logic [IDX_W-1:0]   idx_o
);
  logic acc, wr_acc, lock_q;
  logic unused_addr_hi;

  assign unused_addr_hi = ^addr_i[ADDR_W-1:IDX_W];
  assign idx_o  = addr_i[IDX_W-1:0];
  assign acc    = sel_i && !mem_en_i;
  assign wr_acc = acc && wr_i;

  always_comb begin
    req_o = '0;
    rel_o = '0;
    if (wr_acc) begin
      if (wbit_i) rel_o[idx_o] = 1'b1;
      else        req_o[idx_o] = 1'b1;
    end
  end

  // read-back blocked until select or output enable drops after a write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                lock_q <= 1'b0;
    else if (wr_acc)            lock_q <= 1'b1;
    else if (!sel_i || !oe_i)   lock_q <= 1'b0;
  end

  assign rd_o = acc && !wr_i && oe_i && !lock_q;

  // R8
  wr_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_acc |=> !rd_o);
endmodule

// File: rtl/sem_latch.sv
module sem_latch
  import sem_bank_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_l_i,
  input  logic rel_l_i,
  input  logic req_r_i,
  input  logic rel_r_i,
  output own_e owner_o,
  output logic pend_l_o,
  output logic pend_r_o
);
  own_e owner_q, owner_d;
  logic pend_l_q, pend_r_q, pend_l_d, pend_r_d;

  always_comb begin
    owner_d  = owner_q;
    pend_l_d = pend_l_q;
    pend_r_d = pend_r_q;
    // releases and withdrawals first
    if (rel_l_i) begin
      pend_l_d = 1'b0;
      if (owner_d == OWN_LEFT) owner_d = OWN_NONE;
    end
    if (rel_r_i) begin
      pend_r_d = 1'b0;
      if (owner_d == OWN_RIGHT) owner_d = OWN_NONE;
    end
    if (req_l_i) pend_l_d = 1'b1;
    if (req_r_i) pend_r_d = 1'b1;
    // free token goes to a waiting port, left first
    if (owner_d == OWN_NONE) begin
      if (pend_l_d)      owner_d = OWN_LEFT;
      else if (pend_r_d) owner_d = OWN_RIGHT;
    end
    if (owner_d == OWN_LEFT)  pend_l_d = 1'b0;
    if (owner_d == OWN_RIGHT) pend_r_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owner_q  <= OWN_NONE;
      pend_l_q <= 1'b0;
      pend_r_q <= 1'b0;
    end else begin
      owner_q  <= owner_d;
      pend_l_q <= pend_l_d;
      pend_r_q <= pend_r_d;
    end
  end

  assign owner_o  = owner_q;
  assign pend_l_o = pend_l_q;
  assign pend_r_o = pend_r_q;

  // R4
  handover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_q == OWN_RIGHT && pend_l_q && rel_r_i && !rel_l_i) |=> owner_q == OWN_LEFT);
  // R6
  tie_left_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_q == OWN_NONE && req_l_i && req_r_i) |=> (owner_q == OWN_LEFT && pend_r_q));
  // R4
  holder_not_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((owner_q == OWN_LEFT && pend_l_q) || (owner_q == OWN_RIGHT && pend_r_q)));
endmodule

// File: rtl/sem_bank.sv
module sem_bank
  import sem_bank_pkg::*;
#(
  parameter int NUM_SEM = 8,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              l_sem_sel_i,
  input  logic              l_mem_en_i,
  input  logic              l_wr_i,
  input  logic              l_oe_i,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic [DATA_W-1:0] l_wdata_i,
  output logic [DATA_W-1:0] l_rdata_o,
  output logic              l_rd_vld_o,
  input  logic              r_sem_sel_i,
  input  logic              r_mem_en_i,
  input  logic              r_wr_i,
  input  logic              r_oe_i,
  input  logic [ADDR_W-1:0] r_addr_i,
  input  logic [DATA_W-1:0] r_wdata_i,
  output logic [DATA_W-1:0] r_rdata_o,
  output logic              r_rd_vld_o
);
  localparam int IDX_W = (NUM_SEM > 1) ? $clog2(NUM_SEM) : 1;

  logic [NUM_SEM-1:0] l_req, l_rel, r_req, r_rel;
  logic [NUM_SEM-1:0] pend_l, pend_r;
  logic               l_rd, r_rd;
  logic [IDX_W-1:0]   l_idx, r_idx;
  own_e               own [NUM_SEM];
  logic               l_bit, r_bit;
  logic               unused_wdata_hi;

  assign unused_wdata_hi = ^{l_wdata_i[DATA_W-1:1], r_wdata_i[DATA_W-1:1]};

  sem_port_dec #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W)) u_l_dec (
    .clk_i, .rst_ni,
    .sel_i(l_sem_sel_i), .mem_en_i(l_mem_en_i), .wr_i(l_wr_i), .oe_i(l_oe_i),
    .addr_i(l_addr_i), .wbit_i(l_wdata_i[0]),
    .req_o(l_req), .rel_o(l_rel), .rd_o(l_rd), .idx_o(l_idx)
  );

  sem_port_dec #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W)) u_r_dec (
    .clk_i, .rst_ni,
    .sel_i(r_sem_sel_i), .mem_en_i(r_mem_en_i), .wr_i(r_wr_i), .oe_i(r_oe_i),
    .addr_i(r_addr_i), .wbit_i(r_wdata_i[0]),
    .req_o(r_req), .rel_o(r_rel), .rd_o(r_rd), .idx_o(r_idx)
  );

  for (genvar k = 0; k < NUM_SEM; k++) begin : g_sem
    sem_latch u_latch (
      .clk_i, .rst_ni,
      .req_l_i(l_req[k]), .rel_l_i(l_rel[k]),
      .req_r_i(r_req[k]), .rel_r_i(r_rel[k]),
      .owner_o(own[k]), .pend_l_o(pend_l[k]), .pend_r_o(pend_r[k])
    );
  end

  assign l_bit = (own[l_idx] != OWN_LEFT);
  assign r_bit = (own[r_idx] != OWN_RIGHT);

  assign l_rd_vld_o = l_rd;
  assign r_rd_vld_o = r_rd;
  assign l_rdata_o  = l_rd ? {DATA_W{l_bit}} : '1;
  assign r_rdata_o  = r_rd ? {DATA_W{r_bit}} : '1;

  // R2
  single_holder_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_rd_vld_o && r_rd_vld_o && l_idx == r_idx) |-> (l_rdata_o[0] || r_rdata_o[0]));
  // R9
  l_repl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_rdata_o == '0) || (l_rdata_o == '1));
  // R9
  r_idle_ones_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !r_rd_vld_o |-> r_rdata_o == '1);
endmodule

// File: tb/sem_bank_tb.sv
module sem_bank_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic l_sel = 0, l_men = 0, l_wr = 0, l_oe = 0;
  logic r_sel = 0, r_men = 0, r_wr = 0, r_oe = 0;
  logic [ADDR_W-1:0] l_addr = '0, r_addr = '0;
  logic [DATA_W-1:0] l_wd = '0, r_wd = '0;
  logic [DATA_W-1:0] l_rd, r_rd;
  logic l_vld, r_vld;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sem_bank #(.NUM_SEM(8), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .l_sem_sel_i(l_sel), .l_mem_en_i(l_men), .l_wr_i(l_wr), .l_oe_i(l_oe),
    .l_addr_i(l_addr), .l_wdata_i(l_wd), .l_rdata_o(l_rd), .l_rd_vld_o(l_vld),
    .r_sem_sel_i(r_sel), .r_mem_en_i(r_men), .r_wr_i(r_wr), .r_oe_i(r_oe),
    .r_addr_i(r_addr), .r_wdata_i(r_wd), .r_rdata_o(r_rd), .r_rd_vld_o(r_vld)
  );

  task automatic check(input string req, input logic [DATA_W:0] got, input logic [DATA_W:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got vld/data %h expected %h", req, got, exp);
    end
  endtask

  task automatic clear_side(input bit right);
    if (right) begin r_sel = 0; r_men = 0; r_wr = 0; r_oe = 0; end
    else       begin l_sel = 0; l_men = 0; l_wr = 0; l_oe = 0; end
  endtask

  task automatic drive(input bit right, input bit wr, input bit men,
                       input logic [ADDR_W-1:0] a, input bit b);
    if (right) begin
      r_sel = 1; r_men = men; r_wr = wr; r_oe = !wr; r_addr = a; r_wd = {DATA_W{b}};
    end else begin
      l_sel = 1; l_men = men; l_wr = wr; l_oe = !wr; l_addr = a; l_wd = {DATA_W{b}};
    end
  endtask

  task automatic sem_wr(input bit right, input logic [ADDR_W-1:0] a, input bit b, input bit men = 0);
    @(negedge clk); drive(right, 1, men, a, b);
    @(negedge clk); clear_side(right);
  endtask

  task automatic both_wr(input logic [ADDR_W-1:0] a, input bit b);
    @(negedge clk); drive(0, 1, 0, a, b); drive(1, 1, 0, a, b);
    @(negedge clk); clear_side(0); clear_side(1);
  endtask

  // reads and checks vld + replicated bit
  task automatic sem_rd(input string req, input bit right, input logic [ADDR_W-1:0] a,
                        input bit exp_vld, input bit exp_bit, input bit men = 0);
    @(negedge clk); drive(right, 0, men, a, 1'b1);
    #1;
    if (right) check(req, {r_vld, r_rd}, {exp_vld, exp_vld ? {DATA_W{exp_bit}} : {DATA_W{1'b1}}});
    else       check(req, {l_vld, l_rd}, {exp_vld, exp_vld ? {DATA_W{exp_bit}} : {DATA_W{1'b1}}});
    @(negedge clk); clear_side(right);
  endtask

  task automatic t_reset;
    for (int k = 0; k < 8; k++) begin
      sem_rd("R1", 0, ADDR_W'(k), 1, 1);
      sem_rd("R1", 1, ADDR_W'(k), 1, 1);
    end
  endtask

  task automatic t_grant;
    sem_wr(0, 12'h003, 0);
    sem_rd("R2", 0, 12'h003, 1, 0);
    sem_rd("R2", 1, 12'h003, 1, 1);
  endtask

  task automatic t_addr;
    sem_wr(1, 12'hA05, 0);
    sem_rd("R3", 1, 12'h005, 1, 0);
    sem_rd("R3", 0, 12'h7F5, 1, 1);
    sem_rd("R3", 1, 12'hFF4, 1, 1);
  endtask

  task automatic t_pending;
    sem_wr(1, 12'h003, 0);
    sem_rd("R4", 1, 12'h003, 1, 1);
    sem_wr(0, 12'h003, 1);
    sem_rd("R4", 1, 12'h003, 1, 0);
    sem_rd("R4", 0, 12'h003, 1, 1);
    sem_wr(1, 12'h003, 1);
  endtask

  task automatic t_cancel;
    sem_wr(0, 12'h005, 0);
    sem_rd("R5", 0, 12'h005, 1, 1);
    sem_wr(0, 12'h005, 1);
    sem_wr(1, 12'h005, 1);
    sem_rd("R5", 0, 12'h005, 1, 1);
    sem_rd("R5", 1, 12'h005, 1, 1);
    sem_wr(1, 12'h005, 0);
    sem_rd("R5", 1, 12'h005, 1, 0);
    sem_wr(1, 12'h005, 1);
  endtask

  task automatic t_tie;
    both_wr(12'h006, 0);
    sem_rd("R6", 0, 12'h006, 1, 0);
    sem_rd("R6", 1, 12'h006, 1, 1);
    sem_wr(0, 12'h006, 1);
    sem_rd("R6", 1, 12'h006, 1, 0);
    sem_rd("R6", 0, 12'h006, 1, 1);
    sem_wr(1, 12'h006, 1);
  endtask

  task automatic t_mem_en;
    sem_wr(0, 12'h007, 0, 1);
    sem_rd("R7", 0, 12'h007, 1, 1);
    sem_rd("R7", 1, 12'h007, 1, 1);
    sem_rd("R7", 0, 12'h007, 0, 1, 1);
  endtask

  task automatic t_lock;
    @(negedge clk); drive(0, 1, 0, 12'h000, 0); l_oe = 0;
    @(negedge clk); l_wr = 0; l_oe = 1;
    #1 check("R8", {l_vld, l_rd}, {1'b0, {DATA_W{1'b1}}});
    @(negedge clk);
    #1 check("R8", {l_vld, l_rd}, {1'b0, {DATA_W{1'b1}}});
    @(negedge clk); l_oe = 0;
    @(negedge clk); l_oe = 1;
    #1 check("R8 R9", {l_vld, l_rd}, {1'b1, {DATA_W{1'b0}}});
    @(negedge clk); clear_side(0);
    sem_wr(0, 12'h000, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 3 + 2);
    rst_n = 1'b1;
    t_reset();
    t_grant();
    t_addr();
    t_pending();
    t_cancel();
    t_tie();
    t_mem_en();
    t_lock();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule